// File: doc/BRIEF.md
# Start-up Vector Sequencer

This block brings a processor core out of reset. Once the synchronous, active-low reset is released it waits a fixed number of settling cycles so neighbouring units can finish their own reset. It then issues two word reads over a simple request/acknowledge port. The first read fetches the initial stack pointer and the second fetches the initial program counter. Both come from fixed locations at the very top of the address space.

The program counter register is wider than an address. Its low 12 bits hold a micro-code instruction pointer, and the macro address sits above them. A vector word is therefore loaded shifted left by 12 places, with the micro-code field cleared. The fetch address and PC-relative targets are formed from the upper field only. Until the sequence has loaded the program counter, the block blocks every exception-redirect request. This prevents the PC from being taken from an exception vector register that has not been written yet.

After the program counter is loaded, a one-cycle done pulse is issued and a level status stays high. The block then sits idle until the next reset.

Top module: `boot_vector_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_req_o`, `boot_done_o`, `booted_o` and `exc_redirect_o` are 0, and `sp_o` and `pc_o` are all zeros.
- R2: After reset is released, `rd_req_o` first goes high exactly SETTLE_CYCLES (default 6) rising edges later.
- R3: The first read addresses the stack-pointer vector at 2^ADDR_W − 2·(ADDR_W/8) (0xFFFF_FFF8 by default). The second read addresses the program-counter vector at 2^ADDR_W − ADDR_W/8 (0xFFFF_FFFC by default). No other reads occur.
- R4: While `rd_req_o` is high and `rd_ack_i` is low, the request stays high and `rd_addr_o` does not change. Data is taken on the edge where `rd_ack_i` is high.
- R5: The word returned by the first read appears on `sp_o` from the cycle after its acknowledge.
- R6: The word returned by the second read is loaded into `pc_o` as {word, 12'h000}, so the micro-code pointer field is zero. `fetch_addr_o` equals `pc_o[ADDR_W+11:12]`.
- R7: `rel_target_o` equals `fetch_addr_o + disp_i`, modulo 2^ADDR_W.
- R8: `boot_done_o` is high for exactly the one cycle after the program-counter acknowledge. `booted_o` rises with it and stays high. After that, no request is raised, and any acknowledge leaves `sp_o` and `pc_o` unchanged.
- R9: `exc_redirect_o` is 0 whenever `booted_o` is 0. Once `booted_o` is 1, `exc_redirect_o` follows `exc_req_i`.
- R10: A reset asserted partway through the sequence returns every output to its R1 value, and the whole sequence restarts after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req_o | output | 1 | Vector read request |
| rd_addr_o | output | ADDR_W | Vector read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | ADDR_W | Read data |
| exc_req_i | input | 1 | Exception redirect request from the pipeline |
| exc_redirect_o | output | 1 | Gated exception redirect |
| disp_i | input | ADDR_W | PC-relative displacement |
| sp_o | output | ADDR_W | Stack pointer register |
| pc_o | output | ADDR_W+12 | Program counter with micro-code pointer field |
| fetch_addr_o | output | ADDR_W | Macro fetch address (PC upper field) |
| rel_target_o | output | ADDR_W | PC-relative target |
| boot_done_o | output | 1 | One-cycle start-up done pulse |
| booted_o | output | 1 | Start-up complete level |

## Verification
The hardest case to reach is a reset that lands in the middle of the sequence. At that point the settle delay has expired and the stack-pointer request is pending but has not been acknowledged. The bench creates this case by releasing reset and waiting for the request. It then asserts reset again instead of acknowledging, and checks that a full boot with new vector values follows cleanly. The bench also holds acknowledges back for several cycles to test request stability. It raises an exception request throughout the sequence and sends a stray acknowledge after completion, to confirm both have no effect.

// File: rtl/boot_seq_pkg.sv
// Package: shared types for the start-up vector sequencer.
// Assumes: nothing beyond a synchronous design flow.
package boot_seq_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE   = 2'd0,
        ST_FETCH_SP = 2'd1,
        ST_FETCH_PC = 2'd2,
        ST_RUN      = 2'd3
    } boot_state_e;

endpackage

// File: rtl/boot_settle_timer.sv
// Module: counts settling cycles after reset release and flags expiry.
// Assumes: CYCLES >= 1; en stays high until expired_o has been seen.
module boot_settle_timer #(
    parameter int CYCLES = 6,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expired_o = en && (cnt_q == CNT_W'(CYCLES - 1));

    // Advance the count while waiting and not yet at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en && !expired_o)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/boot_vec_regs.sv
// Module: stack pointer and micro-coded program counter registers, plus
// fetch address and PC-relative target formed from the PC upper field.
// Assumes: ld_sp and ld_pc are never high together.
module boot_vec_regs #(
    parameter int ADDR_W = 32,
    parameter int UPC_W  = 12,
    localparam int PC_W  = ADDR_W + UPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_sp,
    input  logic              ld_pc,
    input  logic [ADDR_W-1:0] word_i,
    input  logic [ADDR_W-1:0] disp_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [ADDR_W-1:0] rel_target_o
);
    logic [ADDR_W-1:0] sp_q;
    logic [PC_W-1:0]   pc_q;

    // Load the stack pointer from the first vector word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (ld_sp)
            sp_q <= word_i;
    end

    // Load the PC shifted above a cleared micro-code pointer field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (ld_pc)
            pc_q <= {word_i, {UPC_W{1'b0}}};
    end

    assign sp_o         = sp_q;
    assign pc_o         = pc_q;
    assign fetch_addr_o = pc_q[PC_W-1:UPC_W];
    assign rel_target_o = pc_q[PC_W-1:UPC_W] + disp_i;
endmodule

// File: rtl/boot_vector_sequencer.sv
// Module: start-up sequencer. Waits SETTLE_CYCLES after reset release,
// reads the stack pointer vector and then the PC vector from the top of
// memory, and blocks exception redirects until the PC is loaded.
// Assumes: the memory holds data valid whenever it raises rd_ack_i.
module boot_vector_sequencer #(
    parameter int ADDR_W        = 32,
    parameter int UPC_W         = 12,
    parameter int SETTLE_CYCLES = 6,
    localparam int PC_W         = ADDR_W + UPC_W,
    localparam int WORD_BYTES   = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [ADDR_W-1:0] rd_data_i,
    input  logic              exc_req_i,
    output logic              exc_redirect_o,
    input  logic [ADDR_W-1:0] disp_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [ADDR_W-1:0] rel_target_o,
    output logic              boot_done_o,
    output logic              booted_o
);
    import boot_seq_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
    localparam logic [ADDR_W-1:0] PC_VEC   = ADDR_TOP - ADDR_W'(WORD_BYTES - 1);
    localparam logic [ADDR_W-1:0] SP_VEC   = PC_VEC - ADDR_W'(WORD_BYTES);

    boot_state_e state_q, state_d;
    logic        settle_done;
    logic        ld_sp, ld_pc;
    logic        done_q;

    boot_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state_q == ST_SETTLE),
        .expired_o (settle_done)
    );

    // Next-state and load strobes of the start-up sequence.
    always_comb begin
        state_d = state_q;
        ld_sp   = 1'b0;
        ld_pc   = 1'b0;
        unique case (state_q)
            ST_SETTLE:   if (settle_done) state_d = ST_FETCH_SP;
            ST_FETCH_SP: if (rd_ack_i) begin
                             ld_sp   = 1'b1;
                             state_d = ST_FETCH_PC;
                         end
            ST_FETCH_PC: if (rd_ack_i) begin
                             ld_pc   = 1'b1;
                             state_d = ST_RUN;
                         end
            ST_RUN:      state_d = ST_RUN;
            default:     state_d = ST_SETTLE;
        endcase
    end

    // State register with a defined reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SETTLE;
        else
            state_q <= state_d;
    end

    // One-cycle done pulse registered alongside the PC load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= ld_pc;
    end

    boot_vec_regs #(.ADDR_W(ADDR_W), .UPC_W(UPC_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_sp        (ld_sp),
        .ld_pc        (ld_pc),
        .word_i       (rd_data_i),
        .disp_i       (disp_i),
        .sp_o         (sp_o),
        .pc_o         (pc_o),
        .fetch_addr_o (fetch_addr_o),
        .rel_target_o (rel_target_o)
    );

    assign rd_req_o       = (state_q == ST_FETCH_SP) || (state_q == ST_FETCH_PC);
    assign rd_addr_o      = (state_q == ST_FETCH_PC) ? PC_VEC : SP_VEC;
    assign booted_o       = (state_q == ST_RUN);
    assign boot_done_o    = done_q;
    assign exc_redirect_o = exc_req_i && booted_o;
endmodule

// File: rtl/boot_vector_sequencer_chk.sv
// Module: protocol and sequencing assertions for boot_vector_sequencer,
// attached by bind below.
// Assumes: sampled on the same clock and reset as the sequencer.
module boot_vector_sequencer_chk #(
    parameter int ADDR_W = 32,
    parameter int UPC_W  = 12,
    localparam int PC_W  = ADDR_W + UPC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              exc_redirect_o,
    input logic [PC_W-1:0]   pc_o,
    input logic              boot_done_o,
    input logic              booted_o
);
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o |=> !boot_done_o);

    assert_done_with_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o |-> booted_o);

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        booted_o |=> booted_o);

    assert_no_req_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        booted_o |-> !rd_req_o);

    assert_redirect_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !booted_o |-> !exc_redirect_o);

    assert_upc_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        booted_o |-> (pc_o[UPC_W-1:0] == '0));
endmodule

bind boot_vector_sequencer boot_vector_sequencer_chk #(
    .ADDR_W(ADDR_W), .UPC_W(UPC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_req_o       (rd_req_o),
    .rd_addr_o      (rd_addr_o),
    .rd_ack_i       (rd_ack_i),
    .exc_redirect_o (exc_redirect_o),
    .pc_o           (pc_o),
    .boot_done_o    (boot_done_o),
    .booted_o       (booted_o)
);

// File: tb/boot_vector_sequencer_bench.sv
`timescale 1ns/1ps
module boot_vector_sequencer_bench;
    localparam int AW     = 32;
    localparam int PW     = AW + 12;
    localparam int SETTLE = 6;
    localparam logic [AW-1:0] SP_ADDR = 32'hFFFF_FFF8;
    localparam logic [AW-1:0] PC_ADDR = 32'hFFFF_FFFC;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_req, rd_ack, exc_req, exc_redirect, boot_done, booted;
    logic [AW-1:0] rd_addr, rd_data, disp, sp, fetch_addr, rel_target;
    logic [PW-1:0] pc;

    int checks   = 0;
    int failures = 0;
    logic [AW-1:0] exp_addr_q[$];

    always #2.5 clk = ~clk;

    boot_vector_sequencer #(.ADDR_W(AW), .UPC_W(12), .SETTLE_CYCLES(SETTLE)) u_boot_vector_sequencer (
        .clk(clk), .rst_n(rst_n), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_ack_i(rd_ack), .rd_data_i(rd_data), .exc_req_i(exc_req),
        .exc_redirect_o(exc_redirect), .disp_i(disp), .sp_o(sp), .pc_o(pc),
        .fetch_addr_o(fetch_addr), .rel_target_o(rel_target),
        .boot_done_o(boot_done), .booted_o(booted)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected address for each handshake seen.
    always begin
        @(negedge clk);
        #1;
        if (rst_n === 1'b1 && rd_req === 1'b1 && rd_ack === 1'b1) begin
            if (exp_addr_q.size() == 0)
                chk("R3 unexpected read", {32'h0, rd_addr}, 64'h0);
            else
                chk("R3 vector address", {32'h0, rd_addr}, {32'h0, exp_addr_q.pop_front()});
        end
    end

    task automatic check_reset_state(input string req);
        chk({req, " rd_req"}, {63'h0, rd_req}, 64'h0);
        chk({req, " done"}, {63'h0, boot_done}, 64'h0);
        chk({req, " booted"}, {63'h0, booted}, 64'h0);
        chk({req, " redirect"}, {63'h0, exc_redirect}, 64'h0);
        chk({req, " sp"}, {32'h0, sp}, 64'h0);
        chk({req, " pc"}, {20'h0, pc}, 64'h0);
    endtask

    // Serve one read after a given ack delay; starts at a negedge with rd_req high.
    task automatic serve(input logic [AW-1:0] word, input int delay);
        logic [AW-1:0] a0 = rd_addr;
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk("R4 request held", {63'h0, rd_req}, 64'h1);
            chk("R4 address stable", {32'h0, rd_addr}, {32'h0, a0});
        end
        rd_ack  = 1'b1;
        rd_data = word;
        @(negedge clk);
        rd_ack  = 1'b0;
        rd_data = '0;
    endtask

    // Driver: pushes expected reads, releases reset, answers both vectors.
    task automatic boot(input logic [AW-1:0] spv, input logic [AW-1:0] pcv, input int delay);
        int k = 0;
        exp_addr_q.push_back(SP_ADDR);
        exp_addr_q.push_back(PC_ADDR);
        exc_req = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        while (k < 50) begin
            @(negedge clk);
            k++;
            if (rd_req === 1'b1) break;
            chk("R9 redirect blocked in settle", {63'h0, exc_redirect}, 64'h0);
        end
        chk("R2 settle length", k, SETTLE);
        serve(spv, delay);
        chk("R5 stack pointer loaded", {32'h0, sp}, {32'h0, spv});
        chk("R8 not yet booted", {63'h0, booted}, 64'h0);
        chk("R9 redirect blocked mid", {63'h0, exc_redirect}, 64'h0);
        if (rd_req !== 1'b1) chk("R3 second request", {63'h0, rd_req}, 64'h1);
        serve(pcv, delay);
        chk("R8 done pulse high", {63'h0, boot_done}, 64'h1);
        chk("R8 booted", {63'h0, booted}, 64'h1);
        chk("R6 pc shifted", {20'h0, pc}, {20'h0, pcv, 12'h000});
        chk("R6 fetch address", {32'h0, fetch_addr}, {32'h0, pcv});
        chk("R9 redirect follows", {63'h0, exc_redirect}, 64'h1);
        @(negedge clk);
        chk("R8 done pulse low", {63'h0, boot_done}, 64'h0);
        chk("R8 booted holds", {63'h0, booted}, 64'h1);
        chk("R3 all reads seen", exp_addr_q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; rd_ack = 1'b0; rd_data = '0; exc_req = 1'b1; disp = '0;
        repeat (3) @(negedge clk);
        check_reset_state("R1");

        boot(32'h0000_8000, 32'hFFFC_0100, 3);

        // R7: relative targets, including wrap-around
        disp = 32'h0000_0010;
        #1 chk("R7 target forward", {32'h0, rel_target}, 64'hFFFC_0110);
        disp = 32'hFFFF_0000;
        #1 chk("R7 target wrap", {32'h0, rel_target}, 64'hFFFB_0100);

        // R8: stray acknowledge after completion is ignored
        @(negedge clk);
        rd_ack = 1'b1; rd_data = 32'hDEAD_BEEF;
        @(negedge clk);
        rd_ack = 1'b0; rd_data = '0;
        @(negedge clk);
        chk("R8 sp unchanged", {32'h0, sp}, 64'h0000_8000);
        chk("R8 pc unchanged", {20'h0, pc}, {20'h0, 32'hFFFC_0100, 12'h000});
        chk("R8 no request", {63'h0, rd_req}, 64'h0);
        exc_req = 1'b0;
        #1 chk("R9 redirect off", {63'h0, exc_redirect}, 64'h0);

        // R10: reset in the middle of the sequence
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 reassert");
        rst_n = 1'b1;
        for (int i = 0; i < 30 && rd_req !== 1'b1; i++) @(negedge clk);
        chk("R10 pending request", {63'h0, rd_req}, 64'h1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("R10");
        boot(32'h1234_5670, 32'h0000_4000, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule